// File: doc/BRIEF.md
# Board Control Register Bank

This block is a bank of memory-mapped control and status registers for a development board. A host drives a 20-bit byte offset, a write strobe and a 32-bit write value on a simple synchronous bus. Writes take effect at the clock edge. Read data is a combinational function of the current offset, so a read completes in the same cycle and changes no state.

The bank holds an 8-bit LED bar and an eight-character text buffer for a small display. The buffer can be loaded one character at a time, or in a single write that turns a 32-bit word into its eight uppercase hexadecimal digits. The bank also holds a break value, a general-purpose output byte, a fixed board-status word and a set of registers that let software bit-bang a two-wire I2C link. The I2C output register drives the clock and data lines, and the slave's data level is read back through the I2C input register. Writing one specific magic value to the reset register raises a single-cycle soft-reset request.

Top module: `board_ctrl_regs`

## Requirements
- R1: Offsets that are not listed in R2 to R13 read as zero. Writes to them change no register and no output.
- R2: Offset 0x200 (switch bank) and offset 0x210 (jumper bank) always read zero, and writes to them are ignored.
- R3: Offset 0x208 (board status) reads 0x12 when the BIG_ENDIAN parameter is 1 and 0x10 when it is 0.
- R4: Offset 0x408 is the LED bar. It keeps bits 7:0 of a write, drives `led_bar`, and resets to 0.
- R5: A write of exactly 0x00000042 to offset 0x500 makes `soft_reset_req` high for the one clock cycle after the write edge. Any other value written there leaves it low.
- R6: A write to offset 0x410 loads the text buffer with the eight uppercase hexadecimal ASCII digits of the write value. The most significant nibble goes to character 0, which is `disp_chars[7:0]`. Character k sits at `disp_chars[8k+7:8k]`. Offset 0x410 reads as zero.
- R7: A write to offset 0x418 + 8k, for k from 0 to 7, stores bits 7:0 of the write value as character k and leaves the other characters unchanged. A write to an offset in that range that is not 8-aligned is ignored.
- R8: After reset, every character of the text buffer is 0x20 (space).
- R9: Offset 0x508 (break) keeps 8 bits and resets to 0x0A. Offset 0xA00 (general output) keeps 8 bits, drives `gp_out`, and resets to 0.
- R10: Offset 0xA08 (general input) returns the full I2C output register while the I2C select bit is 1, and zero while it is 0.
- R11: Offset 0xB00 (I2C input) returns 0x2 with bit 0 replaced by the live level of `i2c_sda_i`.
- R12: Offset 0xB08 (I2C output enable) keeps 2 bits, drives `i2c_oe`, and resets to 0. Offset 0xB18 (I2C select) keeps 1 bit and resets to 1.
- R13: Offset 0xB10 (I2C output) stores the full 32-bit write value and resets to 0x3. Its bit 1 drives `i2c_scl_o` and its bit 0 drives `i2c_sda_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 20 | Byte offset inside the block's window |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write value |
| bus_rdata | output | 32 | Combinational read value at `bus_addr` |
| soft_reset_req | output | 1 | One-cycle soft-reset request |
| led_bar | output | 8 | LED bar levels |
| disp_chars | output | 64 | Text buffer, character k at bits 8k+7:8k |
| gp_out | output | 8 | General-purpose output byte |
| i2c_oe | output | 2 | I2C output-enable bits |
| i2c_scl_o | output | 1 | I2C clock level to the slave |
| i2c_sda_o | output | 1 | I2C data level to the slave |
| i2c_sda_i | input | 1 | I2C data level from the slave |

## Verification
The register paths are tried with values that carry bits above the field width, such as 0x1FF into the LED bar and 0xFFFFFFFE into the select bit. These patterns separate a correct truncation from a full store. The hex loader is fed a word that mixes decimal and alphabetic nibbles, which exposes an off-by-one in the letter offset or reversed character order. Per-character writes are tried at both ends of the window and at an unaligned offset. The soft-reset register is written with the magic value and with a neighbouring value, and the pulse is checked both in the cycle after the write and in the cycle after that. The general-input mux is checked with the select bit set and cleared, and the I2C input is checked with the slave's data line at each level.

// File: rtl/board_ctrl_pkg.sv
package board_ctrl_pkg;

    localparam int OFF_W     = 20;
    localparam int DATA_W    = 32;
    localparam int CHAR_W    = 8;
    localparam int NUM_CHARS = DATA_W / 4;
    localparam int CIDX_W    = $clog2(NUM_CHARS);
    localparam int TEXT_W    = NUM_CHARS * CHAR_W;

    localparam logic [OFF_W-1:0] OFF_SWITCH  = 20'h00200;
    localparam logic [OFF_W-1:0] OFF_STATUS  = 20'h00208;
    localparam logic [OFF_W-1:0] OFF_JUMPER  = 20'h00210;
    localparam logic [OFF_W-1:0] OFF_LED     = 20'h00408;
    localparam logic [OFF_W-1:0] OFF_HEXWORD = 20'h00410;
    localparam logic [OFF_W-1:0] OFF_CHAR0   = 20'h00418;
    localparam logic [OFF_W-1:0] OFF_SOFTRST = 20'h00500;
    localparam logic [OFF_W-1:0] OFF_BREAK   = 20'h00508;
    localparam logic [OFF_W-1:0] OFF_GPOUT   = 20'h00A00;
    localparam logic [OFF_W-1:0] OFF_GPIN    = 20'h00A08;
    localparam logic [OFF_W-1:0] OFF_I2CIN   = 20'h00B00;
    localparam logic [OFF_W-1:0] OFF_I2COE   = 20'h00B08;
    localparam logic [OFF_W-1:0] OFF_I2COUT  = 20'h00B10;
    localparam logic [OFF_W-1:0] OFF_I2CSEL  = 20'h00B18;

    localparam logic [OFF_W-1:0] CHAR_SPAN   = OFF_W'((NUM_CHARS - 1) * 8);

    localparam logic [DATA_W-1:0] SOFTRST_KEY = 32'h0000_0042;
    localparam logic [7:0]        BREAK_RST   = 8'h0A;
    localparam logic [DATA_W-1:0] I2CIN_RST   = 32'h0000_0003;
    localparam logic [DATA_W-1:0] I2COUT_RST  = 32'h0000_0003;
    localparam logic [CHAR_W-1:0] SPACE_CHAR  = 8'h20;

    typedef enum logic [3:0] {
        SEL_NONE,
        SEL_SWITCH,
        SEL_STATUS,
        SEL_JUMPER,
        SEL_LED,
        SEL_HEXWORD,
        SEL_CHAR,
        SEL_SOFTRST,
        SEL_BREAK,
        SEL_GPOUT,
        SEL_GPIN,
        SEL_I2CIN,
        SEL_I2COE,
        SEL_I2COUT,
        SEL_I2CSEL
    } reg_sel_e;

    typedef struct packed {
        reg_sel_e            sel;
        logic [CIDX_W-1:0]   cidx;
    } dec_t;

    function automatic logic [CHAR_W-1:0] nib_to_ascii(input logic [3:0] n);
        if (n < 4'd10) return 8'h30 + {4'h0, n};
        return 8'h37 + {4'h0, n};
    endfunction

    function automatic logic [TEXT_W-1:0] word_to_text(input logic [DATA_W-1:0] w);
        logic [TEXT_W-1:0] t;
        t = '0;
        for (int i = 0; i < NUM_CHARS; i++) begin
            t[i*CHAR_W +: CHAR_W] = nib_to_ascii(w[DATA_W-4-4*i +: 4]);
        end
        return t;
    endfunction

endpackage

// File: rtl/bc_decode.sv
module bc_decode
    import board_ctrl_pkg::*;
(
    input  logic [OFF_W-1:0] off,
    output dec_t             dec
);

    logic [OFF_W-1:0] char_delta;

    always_comb begin
        char_delta = off - OFF_CHAR0;
        dec.cidx   = char_delta[CIDX_W+2:3];
        unique case (off)
            OFF_SWITCH:  dec.sel = SEL_SWITCH;
            OFF_STATUS:  dec.sel = SEL_STATUS;
            OFF_JUMPER:  dec.sel = SEL_JUMPER;
            OFF_LED:     dec.sel = SEL_LED;
            OFF_HEXWORD: dec.sel = SEL_HEXWORD;
            OFF_SOFTRST: dec.sel = SEL_SOFTRST;
            OFF_BREAK:   dec.sel = SEL_BREAK;
            OFF_GPOUT:   dec.sel = SEL_GPOUT;
            OFF_GPIN:    dec.sel = SEL_GPIN;
            OFF_I2CIN:   dec.sel = SEL_I2CIN;
            OFF_I2COE:   dec.sel = SEL_I2COE;
            OFF_I2COUT:  dec.sel = SEL_I2COUT;
            OFF_I2CSEL:  dec.sel = SEL_I2CSEL;
            default: begin
                if ((off >= OFF_CHAR0) && (char_delta <= CHAR_SPAN)
                    && (char_delta[2:0] == 3'b000))
                    dec.sel = SEL_CHAR;
                else
                    dec.sel = SEL_NONE;
            end
        endcase
    end

endmodule

// File: rtl/bc_display.sv
module bc_display
    import board_ctrl_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               wr_word,
    input  logic               wr_char,
    input  logic [CIDX_W-1:0]  cidx,
    input  logic [DATA_W-1:0]  wdata,
    output logic [TEXT_W-1:0]  text
);

    logic [TEXT_W-1:0] text_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            text_q <= {NUM_CHARS{SPACE_CHAR}};
        end else if (wr_word) begin
            text_q <= word_to_text(wdata);
        end else if (wr_char) begin
            text_q[cidx*CHAR_W +: CHAR_W] <= wdata[CHAR_W-1:0];
        end
    end

    assign text = text_q;

    assert_text_hold_R7: assert property (@(posedge clk) disable iff (rst)
        (!wr_word && !wr_char) |=> $stable(text));

    assert_word_msn_first_R6: assert property (@(posedge clk) disable iff (rst)
        (wr_word && wdata[DATA_W-1:DATA_W-4] == 4'hF) |=> (text[CHAR_W-1:0] == 8'h46));

endmodule

// File: rtl/bc_i2c.sv
module bc_i2c
    import board_ctrl_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_oe,
    input  logic              wr_out,
    input  logic              wr_sel,
    input  logic [DATA_W-1:0] wdata,
    output logic [1:0]        oe,
    output logic [DATA_W-1:0] out_word,
    output logic              sel,
    output logic              scl_o,
    output logic              sda_o
);

    logic [1:0]        oe_q;
    logic [DATA_W-1:0] out_q;
    logic              sel_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            oe_q  <= 2'b00;
            out_q <= I2COUT_RST;
            sel_q <= 1'b1;
        end else begin
            if (wr_oe)  oe_q  <= wdata[1:0];
            if (wr_out) out_q <= wdata;
            if (wr_sel) sel_q <= wdata[0];
        end
    end

    assign oe       = oe_q;
    assign out_word = out_q;
    assign sel      = sel_q;
    assign scl_o    = out_q[1];
    assign sda_o    = out_q[0];

    assert_lines_follow_write_R13: assert property (@(posedge clk) disable iff (rst)
        wr_out |=> (scl_o == $past(wdata[1]) && sda_o == $past(wdata[0])));

    assert_lines_hold_R13: assert property (@(posedge clk) disable iff (rst)
        !wr_out |=> ($stable(scl_o) && $stable(sda_o)));

    assert_sel_hold_R12: assert property (@(posedge clk) disable iff (rst)
        !wr_sel |=> $stable(sel));

endmodule

// File: rtl/board_ctrl_regs.sv
module board_ctrl_regs
    import board_ctrl_pkg::*;
#(
    parameter bit BIG_ENDIAN = 1'b0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [19:0]       bus_addr,
    input  logic              bus_we,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              soft_reset_req,
    output logic [7:0]        led_bar,
    output logic [63:0]       disp_chars,
    output logic [7:0]        gp_out,
    output logic [1:0]        i2c_oe,
    output logic              i2c_scl_o,
    output logic              i2c_sda_o,
    input  logic              i2c_sda_i
);

    localparam logic [DATA_W-1:0] STATUS_WORD = BIG_ENDIAN ? 32'h12 : 32'h10;

    dec_t              dec;
    logic [7:0]        led_q;
    logic [7:0]        brk_q;
    logic [7:0]        gp_q;
    logic              soft_q;
    logic [DATA_W-1:0] i2c_word;
    logic              i2c_sel;

    bc_decode u_decode (
        .off (bus_addr),
        .dec (dec)
    );

    bc_display u_display (
        .clk     (clk),
        .rst     (rst),
        .wr_word (bus_we && dec.sel == SEL_HEXWORD),
        .wr_char (bus_we && dec.sel == SEL_CHAR),
        .cidx    (dec.cidx),
        .wdata   (bus_wdata),
        .text    (disp_chars)
    );

    bc_i2c u_i2c (
        .clk      (clk),
        .rst      (rst),
        .wr_oe    (bus_we && dec.sel == SEL_I2COE),
        .wr_out   (bus_we && dec.sel == SEL_I2COUT),
        .wr_sel   (bus_we && dec.sel == SEL_I2CSEL),
        .wdata    (bus_wdata),
        .oe       (i2c_oe),
        .out_word (i2c_word),
        .sel      (i2c_sel),
        .scl_o    (i2c_scl_o),
        .sda_o    (i2c_sda_o)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            led_q  <= 8'h00;
            brk_q  <= BREAK_RST;
            gp_q   <= 8'h00;
            soft_q <= 1'b0;
        end else begin
            if (bus_we && dec.sel == SEL_LED)   led_q <= bus_wdata[7:0];
            if (bus_we && dec.sel == SEL_BREAK) brk_q <= bus_wdata[7:0];
            if (bus_we && dec.sel == SEL_GPOUT) gp_q  <= bus_wdata[7:0];
            soft_q <= bus_we && (dec.sel == SEL_SOFTRST) && (bus_wdata == SOFTRST_KEY);
        end
    end

    always_comb begin
        unique case (dec.sel)
            SEL_STATUS: bus_rdata = STATUS_WORD;
            SEL_LED:    bus_rdata = {24'h0, led_q};
            SEL_BREAK:  bus_rdata = {24'h0, brk_q};
            SEL_GPOUT:  bus_rdata = {24'h0, gp_q};
            SEL_GPIN:   bus_rdata = i2c_sel ? i2c_word : '0;
            SEL_I2CIN:  bus_rdata = {I2CIN_RST[DATA_W-1:1], i2c_sda_i};
            SEL_I2COE:  bus_rdata = {30'h0, i2c_oe};
            SEL_I2COUT: bus_rdata = i2c_word;
            SEL_I2CSEL: bus_rdata = {31'h0, i2c_sel};
            default:    bus_rdata = '0;
        endcase
    end

    assign soft_reset_req = soft_q;
    assign led_bar        = led_q;
    assign gp_out         = gp_q;

    assert_softrst_cause_R5: assert property (@(posedge clk) disable iff (rst)
        soft_reset_req |-> $past(bus_we && bus_addr == OFF_SOFTRST && bus_wdata == SOFTRST_KEY));

    assert_led_hold_R4: assert property (@(posedge clk) disable iff (rst)
        !(bus_we && bus_addr == OFF_LED) |=> $stable(led_bar));

    assert_gpout_hold_R9: assert property (@(posedge clk) disable iff (rst)
        !(bus_we && bus_addr == OFF_GPOUT) |=> $stable(gp_out));

    assert_unknown_reads_zero_R1: assert property (@(posedge clk) disable iff (rst)
        (dec.sel == SEL_NONE) |-> (bus_rdata == '0));

    assert_i2cin_live_R11: assert property (@(posedge clk) disable iff (rst)
        (bus_addr == OFF_I2CIN) |-> (bus_rdata[0] == i2c_sda_i));

endmodule

// File: tb/board_ctrl_regs_bench.sv
`timescale 1ns/1ps
module board_ctrl_regs_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [19:0] bus_addr = '0;
    logic        bus_we = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        soft_reset_req;
    logic [7:0]  led_bar;
    logic [63:0] disp_chars;
    logic [7:0]  gp_out;
    logic [1:0]  i2c_oe;
    logic        i2c_scl_o;
    logic        i2c_sda_o;
    logic        i2c_sda_i = 1'b0;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #5 clk = ~clk;

    board_ctrl_regs u_board_ctrl_regs (
        .clk            (clk),
        .rst            (rst),
        .bus_addr       (bus_addr),
        .bus_we         (bus_we),
        .bus_wdata      (bus_wdata),
        .bus_rdata      (bus_rdata),
        .soft_reset_req (soft_reset_req),
        .led_bar        (led_bar),
        .disp_chars     (disp_chars),
        .gp_out         (gp_out),
        .i2c_oe         (i2c_oe),
        .i2c_scl_o      (i2c_scl_o),
        .i2c_sda_o      (i2c_sda_o),
        .i2c_sda_i      (i2c_sda_i)
    );

    typedef struct packed {
        logic        wr;
        logic [19:0] waddr;
        logic [31:0] wdata;
        logic [19:0] raddr;
        logic [31:0] exp;
        logic [7:0]  req;
    } vec_t;

    localparam int NV = 16;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 20'h0,     32'h0,        20'h208, 32'h10,       8'd3},  // R3 little-endian default
        '{1'b1, 20'h408,   32'h1FF,      20'h408, 32'hFF,       8'd4},  // R4 truncation
        '{1'b1, 20'h200,   32'hFF,       20'h200, 32'h0,        8'd2},  // R2 switches
        '{1'b1, 20'h210,   32'hFF,       20'h210, 32'h0,        8'd2},  // R2 jumpers
        '{1'b1, 20'h404,   32'h1234,     20'h404, 32'h0,        8'd1},  // R1 unknown offset
        '{1'b1, 20'hFFFFC, 32'h77,       20'h408, 32'hFF,       8'd1},  // R1 LED untouched
        '{1'b1, 20'h508,   32'h1234,     20'h508, 32'h34,       8'd9},  // R9 break
        '{1'b1, 20'hA00,   32'hABC,      20'hA00, 32'hBC,       8'd9},  // R9 gpout
        '{1'b1, 20'hB08,   32'hFF,       20'hB08, 32'h3,        8'd12}, // R12 oe width
        '{1'b1, 20'hB10,   32'hDEADBEE2, 20'hA08, 32'hDEADBEE2, 8'd10}, // R10 sel=1
        '{1'b0, 20'h0,     32'h0,        20'hB10, 32'hDEADBEE2, 8'd13}, // R13 full store
        '{1'b1, 20'hB18,   32'hFFFFFFFE, 20'hB18, 32'h0,        8'd12}, // R12 select bit0
        '{1'b0, 20'h0,     32'h0,        20'hA08, 32'h0,        8'd10}, // R10 sel=0
        '{1'b1, 20'hB18,   32'h3,        20'hB18, 32'h1,        8'd12}, // R12 select width
        '{1'b0, 20'h0,     32'h0,        20'hB00, 32'h2,        8'd11}, // R11 sda low
        '{1'b1, 20'h410,   32'h1234ABCD, 20'h410, 32'h0,        8'd6}   // R6 write-only
    };

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [19:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr  = a;
        bus_wdata = d;
        bus_we    = 1'b1;
        @(negedge clk);
        bus_we    = 1'b0;
    endtask

    task automatic read_check(input string req, input logic [19:0] a, input logic [31:0] exp);
        @(negedge clk);
        bus_addr = a;
        bus_we   = 1'b0;
        #1;
        check(req, {32'h0, bus_rdata}, {32'h0, exp});
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // Reset state
        check("R4", {56'h0, led_bar}, 64'h0);
        check("R8", disp_chars, 64'h2020202020202020);
        check("R5", {63'h0, soft_reset_req}, 64'h0);
        check("R13", {62'h0, i2c_scl_o, i2c_sda_o}, 64'h3);
        read_check("R9", 20'h508, 32'h0A);
        read_check("R9", 20'hA00, 32'h0);
        read_check("R12", 20'hB08, 32'h0);
        read_check("R12", 20'hB18, 32'h1);
        read_check("R13", 20'hB10, 32'h3);
        read_check("R10", 20'hA08, 32'h3);

        for (int i = 0; i < NV; i++) begin
            if (VECS[i].wr) bus_write(VECS[i].waddr, VECS[i].wdata);
            read_check($sformatf("R%0d vec%0d", VECS[i].req, i), VECS[i].raddr, VECS[i].exp);
        end

        // R6 hex load, character 0 is the top nibble
        check("R6", disp_chars, 64'h44434241_34333231);
        check("R9", {56'h0, gp_out}, 64'hBC);
        check("R12", {62'h0, i2c_oe}, 64'h3);
        check("R13", {62'h0, i2c_scl_o, i2c_sda_o}, 64'h2);

        // R7 per-character writes, ends of the window and an unaligned offset
        bus_write(20'h430, 32'h5A);
        check("R7", disp_chars, 64'h44434241_5A333231);
        bus_write(20'h418, 32'hFFFFFF2E);
        check("R7", disp_chars, 64'h44434241_5A33322E);
        bus_write(20'h450, 32'h7A);
        check("R7", disp_chars, 64'h7A434241_5A33322E);
        bus_write(20'h41C, 32'h21);
        check("R7", disp_chars, 64'h7A434241_5A33322E);
        bus_write(20'h458, 32'h21);
        check("R1", disp_chars, 64'h7A434241_5A33322E);

        // R11 live data level
        i2c_sda_i = 1'b1;
        read_check("R11", 20'hB00, 32'h3);

        // R13 clock/data lines follow the write
        bus_write(20'hB10, 32'h1);
        check("R13", {62'h0, i2c_scl_o, i2c_sda_o}, 64'h1);

        // R5 soft-reset pulse
        bus_write(20'h500, 32'h43);
        check("R5", {63'h0, soft_reset_req}, 64'h0);
        bus_write(20'h500, 32'h142);
        check("R5", {63'h0, soft_reset_req}, 64'h0);
        bus_write(20'h500, 32'h42);
        check("R5", {63'h0, soft_reset_req}, 64'h1);
        @(negedge clk);
        check("R5", {63'h0, soft_reset_req}, 64'h0);

        finish_run();
    end

endmodule